// File: doc/BRIEF.md
# DDR burst column address generator

This block turns a single burst request into the stream of column addresses that a DDR SDRAM burst visits. The request carries a starting column, a burst-length code and an ordering bit. From the clock cycle after the request the block presents one column address per data beat, flags the final one, and returns to idle. The caller uses the stream to index the page buffer that feeds or receives the beats.

Short bursts of 2, 4 or 8 beats stay inside the aligned block of that size that holds the start column, so the upper address bits never change. Within that block the order is either sequential, where the offset is added modulo the length, or interleaved, where the beat index is XORed into the low bits. A full-page burst walks all 256 columns of the page in sequential order, wrapping from the top column back to zero. A full-page request that asks for interleaved order or starts on an odd column is refused with a one-cycle error pulse, and no addresses follow.

Top module: `colBurstGen`

## Requirements
- R1: After reset, colValid, colLast and cfgErr are all low until a request is accepted.
- R2: lenCode selects the beat count: 0 gives 2 beats, 1 gives 4, 2 gives 8, 3 gives a full page of 256. colValid is high for exactly that many consecutive cycles, starting the cycle after the accepted start.
- R3: With interleave = 0 and a length N below 256, beat k has low log2(N) bits equal to (start column + k) modulo N.
- R4: With interleave = 1 and a length N below 256, beat k has low log2(N) bits equal to the start column's low bits XOR k.
- R5: colLast is high only with the final address of a burst, and colValid is low the cycle after it.
- R6: A full-page burst (lenCode 3, interleave 0, even start) gives beat k the address (start + k) modulo 256, wrapping from 255 to 0.
- R7: A full-page request with interleave = 1 or an odd start column raises cfgErr for exactly the next cycle and produces no valid address.
- R8: A start seen while a burst is running, including in its final beat, is ignored: the running sequence is unchanged and no second burst follows.
- R9: For lengths below 256, the address bits above the low log2(N) bits equal those of the start column on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Burst request, sampled when idle |
| startCol | input | 8 | First column of the burst |
| lenCode | input | 2 | Burst length code: 0=2, 1=4, 2=8, 3=full page |
| interleave | input | 1 | Ordering: 0 sequential, 1 interleaved |
| colAddr | output | 8 | Column address of the current beat |
| colValid | output | 1 | colAddr holds a beat address |
| colLast | output | 1 | Current beat is the last of the burst |
| cfgErr | output | 1 | One-cycle pulse for a refused full-page request |

## Verification
The hardest situation to reach is a request arriving during the final beat of a burst, because the block is still busy at that edge and must drop it, while one cycle later the same request would be taken. The stimulus injects a request with different parameters at a chosen beat index, including the last one, and then confirms that the outputs fall idle right after the burst. Full-page bursts that wrap across column 255 are forced directly with high start columns, while random bursts cover every length and ordering combination.

// File: rtl/colBurstPkg.sv
package colBurstPkg;
  localparam int COL_W = 8;

  typedef enum logic [1:0] {
    LEN_2    = 2'd0,
    LEN_4    = 2'd1,
    LEN_8    = 2'd2,
    LEN_PAGE = 2'd3
  } lenCodeT;

  typedef struct packed {
    logic load;
    logic advance;
  } pathCtlT;

  function automatic logic [COL_W-1:0] lenMask(input logic [1:0] code);
    logic [COL_W-1:0] m;
    case (lenCodeT'(code))
      LEN_2:   m = COL_W'(1);
      LEN_4:   m = COL_W'(3);
      LEN_8:   m = COL_W'(7);
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/burstCtl.sv
module burstCtl
  import colBurstPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] lenCode,
  input  logic       interleave,
  input  logic       startLsb,
  input  logic       atEnd,
  output pathCtlT    ctl,
  output logic       busy,
  output logic       cfgErr
);
  logic busyQ;
  logic errQ;
  logic accept;
  logic illegal;

  assign illegal = (lenCodeT'(lenCode) == LEN_PAGE) && (interleave || startLsb);
  assign accept  = start && !busyQ;

  always_comb begin
    ctl.load    = accept && !illegal;
    ctl.advance = busyQ && !atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      errQ <= accept && illegal;
      if (ctl.load)
        busyQ <= 1'b1;
      else if (busyQ && atEnd)
        busyQ <= 1'b0;
    end
  end

  assign busy   = busyQ;
  assign cfgErr = errQ;

  // R7: a refused request never produces addresses
  a_r7_err_silent: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !busyQ);

  // R5: the burst closes right after its last beat
  a_r5_end_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && atEnd) |=> !busyQ);

  // R8: a request during a running burst is not taken
  a_r8_busy_ignores_start: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start && !atEnd) |=> (busyQ && !cfgErr));
endmodule

// File: rtl/burstPath.sv
module burstPath
  import colBurstPkg::*;
#(
  parameter int AW = COL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  pathCtlT       ctl,
  input  logic [AW-1:0] startCol,
  input  logic [1:0]    lenCode,
  input  logic          interleave,
  output logic [AW-1:0] colAddr,
  output logic          atEnd
);
  logic [AW-1:0] baseQ;
  logic [AW-1:0] idxQ;
  logic [AW-1:0] maskQ;
  logic          intlQ;
  logic [AW-1:0] seqLow;
  logic [AW-1:0] intlLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      idxQ  <= '0;
      maskQ <= '0;
      intlQ <= 1'b0;
    end else if (ctl.load) begin
      baseQ <= startCol;
      idxQ  <= '0;
      maskQ <= AW'(lenMask(lenCode));
      intlQ <= interleave;
    end else if (ctl.advance) begin
      idxQ <= idxQ + AW'(1);
    end
  end

  always_comb begin
    seqLow  = (baseQ + idxQ) & maskQ;
    intlLow = (baseQ ^ idxQ) & maskQ;
    colAddr = (baseQ & ~maskQ) | (intlQ ? intlLow : seqLow);
  end

  assign atEnd = (idxQ == maskQ);

  // R3: sequential beats step by one, wrapping inside the aligned block
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !intlQ) |=>
      (colAddr == ((($past(colAddr) + AW'(1)) & maskQ) | ($past(colAddr) & ~maskQ))));

  // R9: upper bits are held through the burst
  a_r9_upper_held: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> ((colAddr & ~maskQ) == ($past(colAddr) & ~maskQ)));
endmodule

// File: rtl/colBurstGen.sv
module colBurstGen
  import colBurstPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             colLast,
  output logic             cfgErr
);
  pathCtlT ctl;
  logic    atEnd;
  logic    busy;

  burstCtl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .lenCode    (lenCode),
    .interleave (interleave),
    .startLsb   (startCol[0]),
    .atEnd      (atEnd),
    .ctl        (ctl),
    .busy       (busy),
    .cfgErr     (cfgErr)
  );

  burstPath #(.AW(COL_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .startCol   (startCol),
    .lenCode    (lenCode),
    .interleave (interleave),
    .colAddr    (colAddr),
    .atEnd      (atEnd)
  );

  assign colValid = busy;
  assign colLast  = busy && atEnd;
endmodule

// File: tb/sim_colBurstGen.sv
`timescale 1ns/1ps
module sim_colBurstGen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] startCol = '0;
  logic [1:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic [7:0] colAddr;
  logic       colValid, colLast, cfgErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  colBurstGen u0 (
    .clk(clk), .rstN(rstN), .start(start), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .colAddr(colAddr),
    .colValid(colValid), .colLast(colLast), .cfgErr(cfgErr)
  );

  function automatic int beatsOf(input logic [1:0] code);
    case (code)
      2'd0: return 2;
      2'd1: return 4;
      2'd2: return 8;
      default: return 256;
    endcase
  endfunction

  function automatic logic [7:0] expAddr(input logic [7:0] b, input int n,
                                         input bit intl, input int k);
    logic [7:0] m, low;
    m = 8'(n - 1);
    if (intl) low = (b ^ 8'(k)) & m;
    else      low = 8'(int'(b) + k) & m;
    return (b & ~m) | low;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one burst; injectAt >= 0 pulses a foreign start at that beat.
  task automatic runBurst(input logic [7:0] col, input logic [1:0] len,
                          input bit intl, input int injectAt);
    int n;
    n = beatsOf(len);
    @(negedge clk);
    start = 1'b1; startCol = col; lenCode = len; interleave = intl;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      start = 1'b0;
      chk(colValid === 1'b1, "R2 valid", int'(colValid), 1);
      if (n == 256)
        chk(colAddr === 8'(int'(col) + k), "R6 page addr", int'(colAddr), (int'(col) + k) % 256);
      else
        chk(colAddr === expAddr(col, n, intl, k), intl ? "R4 R9 addr" : "R3 R9 addr",
            int'(colAddr), int'(expAddr(col, n, intl, k)));
      chk(colLast === (k == n - 1), "R5 last", int'(colLast), int'(k == n - 1));
      chk(cfgErr === 1'b0, "R8 no err in burst", int'(cfgErr), 0);
      if (k == injectAt) begin
        start = 1'b1;
        startCol = ~col;
        lenCode = 2'(len + 2'd1);
        interleave = ~intl;
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk(colValid === 1'b0, "R5 R8 idle after last", int'(colValid), 0);
    chk(cfgErr === 1'b0, "R8 no err after", int'(cfgErr), 0);
  endtask

  task automatic runErr(input logic [7:0] col, input bit intl);
    @(negedge clk);
    start = 1'b1; startCol = col; lenCode = 2'd3; interleave = intl;
    @(negedge clk);
    start = 1'b0;
    chk(cfgErr === 1'b1, "R7 err pulse", int'(cfgErr), 1);
    chk(colValid === 1'b0, "R7 no valid", int'(colValid), 0);
    @(negedge clk);
    chk(cfgErr === 1'b0, "R7 err one cycle", int'(cfgErr), 0);
    chk(colValid === 1'b0, "R7 still idle", int'(colValid), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1337);
    repeat (3) @(negedge clk);
    chk(colValid === 1'b0, "R1 valid", int'(colValid), 0);
    chk(colLast === 1'b0, "R1 last", int'(colLast), 0);
    chk(cfgErr === 1'b0, "R1 err", int'(cfgErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(colValid === 1'b0, "R1 idle after reset", int'(colValid), 0);

    // Directed corners
    runBurst(8'h0D, 2'd2, 1'b0, -1);   // R3 wrap in 8-block
    runBurst(8'h0D, 2'd2, 1'b1, -1);   // R4
    runBurst(8'hFF, 2'd0, 1'b0, -1);   // R3 R9 2-beat wrap
    runBurst(8'h46, 2'd1, 1'b1, -1);   // R4
    runBurst(8'hF0, 2'd3, 1'b0, -1);   // R6 wrap 255 -> 0
    runBurst(8'h00, 2'd3, 1'b0, 17);   // R6 with R8 injection
    runBurst(8'h32, 2'd2, 1'b0, 7);    // R8 start in last beat
    runBurst(8'h21, 2'd0, 1'b1, 1);    // R8 start in last beat, 2 beats
    runBurst(8'h95, 2'd1, 1'b0, 1);    // R8 mid burst
    runErr(8'h10, 1'b1);               // R7 interleaved page
    runErr(8'h11, 1'b0);               // R7 odd start
    runErr(8'h13, 1'b1);               // R7 both

    // Random legal bursts and occasional refused requests
    for (int i = 0; i < 60; i++) begin
      logic [7:0] c;
      logic [1:0] l;
      bit it;
      int inj;
      c = 8'($urandom);
      l = 2'($urandom_range(0, 3));
      it = bit'($urandom_range(0, 1));
      inj = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, beatsOf(l) - 1)) : -1;
      if (l == 2'd3 && (it || c[0])) begin
        if ($urandom_range(0, 1) == 1) runErr(c, it);
        else begin
          c[0] = 1'b0;
          runBurst(c, l, 1'b0, inj);
        end
      end else begin
        runBurst(c, l, it, inj);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule